// File: doc/BRIEF.md
# Push-Button Debouncer with Press Pulse

This block cleans up the signal from a mechanical push button that is sampled by a fast system clock of about 200 MHz. The raw contact signal is asynchronous and bounces for several milliseconds on every press and release. The block delivers two outputs. The first is a steady debounced level. The second is a pulse that lasts one clock cycle for each press.

The raw input first passes through a two-stage synchronizer. A stability counter then measures how many consecutive cycles the synchronized sample has disagreed with the current debounced level. The debounced level flips only when that run reaches a threshold parameter. The default threshold is 1,000,000 cycles, which is 5 ms at 200 MHz. Any agreement in between clears the run. A rising-edge detector on the debounced level produces the press pulse, so holding the button down never repeats the event. Downstream logic, such as a lap-capture counter, can use the pulse directly as a count enable.

Top module: `button_conditioner`

## Requirements
- R1: The raw input passes through two synchronizer flops before the stability logic uses it. These two flops add exactly two clock edges of latency ahead of the stability window.
- R2: If the raw input changes and then stays steady, the debounced level takes the new value on exactly the THRESH+2-th rising clock edge after the change.
- R3: A raw pulse or bounce that lasts fewer than THRESH cycles never changes the debounced level. Whenever the synchronized sample matches the debounced level, the run counter returns to zero on the next edge.
- R4: The press output is 1 for exactly one clock cycle. That cycle is the first one in which the debounced level reads 1 after having read 0.
- R5: The press output stays 0 while the button is held and when the debounced level falls. Each press therefore gives exactly one pulse.
- R6: While reset is high, the debounced level reads 0, the press output reads 0 and the synchronizer and counter are cleared. After reset is released, the timing of R2 applies from the release edge.
- R7: The run counter stays below THRESH and never wraps. A button held far longer than the window therefore keeps its debounced level. The default THRESH is 1,000,000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Asynchronous raw button contact, 1 = pressed |
| btn_level | output | 1 | Debounced button level, 1 = pressed |
| btn_press | output | 1 | One-cycle pulse on each debounced press |

## Verification
The bench drives the input at falling clock edges and samples both outputs at the falling edge after each rising edge. It counts rising edges from the stimulus. A change held for at least THRESH cycles must appear on the debounced level exactly THRESH+2 edges after the change: two edges for the synchronizer and THRESH edges for the window. The press pulse must appear in that same sampled cycle and be gone by the next one. A sweep over every pulse width from 1 to 2*THRESH+2 cycles computes this edge arithmetically. It expects the level to fall THRESH+2 edges after the release and expects no change at all for widths below THRESH. The bounce, long-hold and reset sequences are timed from the last raw change or from the reset release, in the same way.

// File: rtl/btn_cond_pkg.sv
package btn_cond_pkg;

    // Default stability window: 5 ms at 200 MHz.
    localparam int DEFAULT_THRESH = 1_000_000;

    // Number of synchronizer flops in front of the stability logic.
    localparam int DEFAULT_SYNC_STAGES = 2;

    // Width of a counter that must hold 0 .. thresh-1.
    function automatic int run_count_bits(input int thresh);
        if (thresh < 3) begin
            return 1;
        end
        return $clog2(thresh);
    endfunction

    // Debounced state carried from the stability stage to the output.
    typedef enum logic {
        LVL_RELEASED = 1'b0,
        LVL_PRESSED  = 1'b1
    } btn_level_e;

    typedef struct packed {
        btn_level_e level;
        logic       press;
    } btn_out_t;

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/btn_stability.sv
module btn_stability
    import btn_cond_pkg::*;
#(
    parameter int THRESH = DEFAULT_THRESH,
    parameter int CW     = run_count_bits(THRESH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample,
    output btn_level_e    level,
    output logic [CW-1:0] run_count
);
    localparam logic [CW-1:0] LAST = CW'(THRESH - 1);

    logic differs;
    logic window_done;

    assign differs     = (sample != logic'(level));
    assign window_done = differs && (run_count == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            level     <= LVL_RELEASED;
            run_count <= '0;
        end else if (!differs) begin
            run_count <= '0;
        end else if (window_done) begin
            level     <= (level == LVL_PRESSED) ? LVL_RELEASED : LVL_PRESSED;
            run_count <= '0;
        end else begin
            run_count <= run_count + 1'b1;
        end
    end
endmodule

// File: rtl/btn_rise.sv
module btn_rise
    import btn_cond_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  btn_level_e level,
    output logic       pulse
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= logic'(level);
    end

    assign pulse = logic'(level) && !prev;
endmodule

// File: rtl/button_conditioner.sv
module button_conditioner
    import btn_cond_pkg::*;
#(
    parameter int THRESH      = DEFAULT_THRESH,
    parameter int SYNC_STAGES = DEFAULT_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_raw,
    output logic btn_level,
    output logic btn_press
);
    localparam int CW = run_count_bits(THRESH);

    logic          sync_q;
    btn_level_e    stab_level;
    logic [CW-1:0] stab_count;
    logic          rise_pulse;
    btn_out_t      outs;

    btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (btn_raw),
        .q   (sync_q)
    );

    btn_stability #(.THRESH(THRESH), .CW(CW)) u_stab (
        .clk       (clk),
        .rst       (rst),
        .sample    (sync_q),
        .level     (stab_level),
        .run_count (stab_count)
    );

    btn_rise u_rise (
        .clk   (clk),
        .rst   (rst),
        .level (stab_level),
        .pulse (rise_pulse)
    );

    assign outs.level = stab_level;
    assign outs.press = rise_pulse;

    assign btn_level = logic'(outs.level);
    assign btn_press = outs.press;
endmodule

// File: rtl/btn_cond_checker.sv
module btn_cond_checker #(
    parameter int THRESH = 1_000_000,
    parameter int CW     = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          sync_q,
    input logic          level,
    input logic [CW-1:0] count,
    input logic          pulse
);
    logic rst_q;

    always_ff @(posedge clk) rst_q <= rst;

    // R6: one edge after reset, all state reads cleared
    always_ff @(posedge clk) begin
        if (rst_q) begin
            a_r6_reset_clears: assert (!level && count == '0 && !pulse)
                else $error("R6: state not cleared by reset");
        end
    end

    // R2: the level flips only at the end of a full window of disagreement
    a_r2_toggle_needs_window: assert property (@(posedge clk) disable iff (rst)
        (level != $past(level)) |->
            ($past(count) == CW'(THRESH - 1) && $past(sync_q) != $past(level)))
        else $error("R2: level changed before the window completed");

    // R3: agreement clears the run
    a_r3_clear_on_match: assert property (@(posedge clk) disable iff (rst)
        (sync_q == level) |=> (count == '0))
        else $error("R3: run counter not cleared on agreement");

    // R4: the pulse marks the first cycle of a high level
    a_r4_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
        pulse |-> (level && !$past(level)))
        else $error("R4: pulse without a rising level");

    // R5: never two pulse cycles in a row
    a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse)
        else $error("R5: pulse longer than one cycle");

    // R7: counter stays within its window
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count < CW'(THRESH - 1) || count == CW'(THRESH - 1))
        else $error("R7: run counter beyond threshold");
endmodule

bind button_conditioner btn_cond_checker #(.THRESH(THRESH), .CW(CW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .sync_q (sync_q),
    .level  (btn_level),
    .count  (stab_count),
    .pulse  (btn_press)
);

// File: tb/button_conditioner_test.sv
module button_conditioner_test;
    localparam int T = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_raw = 1'b0;
    logic btn_level;
    logic btn_press;

    int nchecks = 0;
    int nerrors = 0;
    int cycles  = 0;

    button_conditioner #(.THRESH(T)) uut (
        .clk       (clk),
        .rst       (rst),
        .btn_raw   (btn_raw),
        .btn_level (btn_level),
        .btn_press (btn_press)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            nerrors++;
            $display("FAIL watchdog: run hung, got %0d cycles expected < 50000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        nchecks++;
        if (act !== exp) begin
            nerrors++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        int presses;
        int s;

        // R6: reset state
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R6", "level in reset", btn_level, 1'b0);
            check("R6", "press in reset", btn_press, 1'b0);
        end
        rst = 1'b0;
        tick();

        // R1/R2/R3/R4: sweep every pulse width; level due T+2 edges after each raw change
        for (int w = 1; w <= 2*T + 2; w++) begin
            btn_raw = 1'b1;
            for (int t = 1; t <= w + T + 6; t++) begin
                tick();
                if (t == w) btn_raw = 1'b0;
                check((w >= T) ? "R2" : "R3", "level sweep", btn_level,
                      (w >= T) && (t >= T + 2) && (t < w + T + 2));
                check("R4", "press sweep", btn_press, (w >= T) && (t == T + 2));
            end
        end

        // R3: bounce on press, level must hold until the input settles
        presses = 0;
        for (int i = 0; i < 12; i++) begin
            btn_raw = ~btn_raw;
            tick();
            check("R3", "level during bounce", btn_level, 1'b0);
            if (btn_press) presses++;
        end
        btn_raw = 1'b1;
        for (int t = 1; t <= T + 2; t++) begin
            tick();
            check("R2", "level after settle", btn_level, t == T + 2);
            if (btn_press) presses++;
        end
        // R5/R7: long hold keeps level high with no further pulses
        for (int t = 0; t < 10*T; t++) begin
            tick();
            check("R7", "level held", btn_level, 1'b1);
            check("R5", "no press while held", btn_press, 1'b0);
        end
        check("R5", "one press per bounce-press", presses == 1, 1'b1);

        // R5: bouncing release gives no pulse; fall T+2 edges after settle
        for (int i = 0; i < 12; i++) begin
            btn_raw = ~btn_raw;
            tick();
            check("R3", "level during release bounce", btn_level, 1'b1);
            check("R5", "no press on release", btn_press, 1'b0);
        end
        btn_raw = 1'b0;
        for (int t = 1; t <= T + 4; t++) begin
            tick();
            check("R2", "level after release", btn_level, t < T + 2);
            check("R5", "no press on fall", btn_press, 1'b0);
        end

        // R6: reset while pressed, then rise timed from release
        btn_raw = 1'b1;
        for (int t = 0; t < T + 4; t++) tick();
        check("R2", "level before reset", btn_level, 1'b1);
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R6", "level under reset", btn_level, 1'b0);
            check("R6", "press under reset", btn_press, 1'b0);
        end
        rst = 1'b0;
        s = 0;
        for (int t = 1; t <= T + 4; t++) begin
            tick();
            check("R6", "level after reset release", btn_level, t >= T + 2);
            check("R6", "press after reset release", btn_press, t == T + 2);
        end

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end
endmodule